// File: doc/BRIEF.md
# Uncorrectable-Error Data Path Tagger

This block sits on the data path of an I/O port. It reacts to uncorrectable ECC errors that several data-slice units report, one flag per slice for each quadword beat. Each beat is loaded into a buffer entry together with its transfer kind: DMA write, DMA read, DMA interlocked read, or read-lock. Any flagged beat sets sticky error status and pulses a bus data-error output. A flagged DMA write also sets two write-data error bits. The interrupt request follows the status only while software has enabled it.

On a read-type return, the block starts a packet over an aligned group of buffer entries. It drives a per-slice read-error sideband for every beat of that packet. A header stage turns the sideband into a single-cycle read-data-with-error marker for the downstream I/O channel. Read-lock data marks the failing quadwords bad in the buffer. During the write-unlock that follows, the data-bus output enable is withheld for bad quadwords. The bus therefore floats to its default value on those quadwords, and the write still frees the locked memory bank.

Top module: `uerr_tagger`

## Requirements
- R1: A load beat (`ld_vld`) with any bit of `ld_uerr` set sets status bit 0 (uncorrectable data error) at the next clock edge and raises `bus_derr` for exactly that one cycle; a clean beat sets nothing.
- R2: `ld_kind` encodes 0 = DMA write, 1 = DMA read, 2 = DMA interlocked read, 3 = read-lock; a flagged DMA write also sets status bit 1 (port write-data error) and bit 2 (bus write-data error); other kinds leave bits 1 and 2 clear.
- R3: `irq` is high one cycle after the edge at which status bit 0 is set while `irq_en` is high, and low whenever `irq_en` was low at the previous edge or status bit 0 is clear.
- R4: Status bits are sticky; a `clr_vld` cycle clears each bit whose `clr_mask` bit is 1 (same bit positions as `sts`); a bit set by a load in the same cycle stays set.
- R5: A `ret_start` with `ret_grp` = g starts a return packet over entries g*PKT_BEATS to g*PKT_BEATS+PKT_BEATS-1; from the next edge, `ret_act` is high and `rer_sb` holds the per-slice OR of those entries' read-error flags for exactly PKT_BEATS cycles, then both return to zero.
- R6: `err_pkt` is high for exactly one cycle, the second cycle of a packet, and only if `rer_sb` has any bit set in that packet.
- R7: Flags loaded with kinds 1 and 2 feed `rer_sb`; flags loaded with kinds 0 and 3 do not.
- R8: A kind-3 load marks the flagged slices of its entry bad; one cycle after `wu_vld` with `wu_idx`, `bus_oe` is the inverse of that entry's bad mask, and it is zero in any cycle that follows a cycle without `wu_vld`.
- R9: `alloc_vld` clears the read-error flags and bad marks of entry `alloc_idx`; reset clears all marks, all status and all outputs.
- R10: A `ret_start` while a packet is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_vld | input | 1 | Bus data beat loaded into a buffer entry |
| ld_kind | input | 2 | Transfer kind of the beat |
| ld_idx | input | $clog2(DEPTH) | Buffer entry written |
| ld_uerr | input | NSLICE | Per-slice uncorrectable error flags |
| alloc_vld | input | 1 | Buffer entry reallocated |
| alloc_idx | input | $clog2(DEPTH) | Entry reallocated |
| irq_en | input | 1 | Software interrupt enable |
| clr_vld | input | 1 | Write-one-to-clear access to status |
| clr_mask | input | 3 | Status bits to clear |
| ret_start | input | 1 | Start a read return packet |
| ret_grp | input | GW | Entry group of the packet |
| wu_vld | input | 1 | Write-unlock beat driven from an entry |
| wu_idx | input | $clog2(DEPTH) | Entry of the write-unlock beat |
| sts | output | 3 | Sticky status: bit 0 uncorrectable, bit 1 port write-data, bit 2 bus write-data |
| bus_derr | output | 1 | Bus data-error pulse |
| irq | output | 1 | Interrupt request |
| ret_act | output | 1 | Return packet beat active |
| rer_sb | output | NSLICE | Per-slice read-error sideband |
| err_pkt | output | 1 | One-cycle read-data-with-error marker |
| bus_oe | output | NSLICE | Per-slice data-bus output enable |

## Verification
A wrong flag in the buffer stays hidden until that entry is read. A stale read-error flag appears as a wrong `rer_sb` bit on the first beat of the next packet over its group. A stale bad mark appears as a missing `bus_oe` bit one cycle after a write-unlock of that entry. Status faults show one cycle after the load. Sequencer faults show up as a sideband that is too short or too long, or as a doubled `err_pkt`, within PKT_BEATS+1 cycles of `ret_start`. The bench therefore loads entries across groups and kinds, then reads them back through packets and write-unlocks.

// File: rtl/uerr_pkg.sv
package uerr_pkg;

  typedef enum logic [1:0] {
    KIND_WR   = 2'd0,
    KIND_RD   = 2'd1,
    KIND_IRD  = 2'd2,
    KIND_LOCK = 2'd3
  } xfer_kind_e;

  localparam int STS_W    = 3;
  localparam int STS_UDE  = 0;
  localparam int STS_PWDE = 1;
  localparam int STS_BWDE = 2;

  function automatic logic kind_is_read(xfer_kind_e k);
    return (k == KIND_RD) || (k == KIND_IRD);
  endfunction

endpackage

// File: rtl/uerr_status.sv
module uerr_status
  import uerr_pkg::*;
#(
  parameter int NSLICE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_vld,
  input  xfer_kind_e        ld_kind,
  input  logic [NSLICE-1:0] ld_uerr,
  input  logic              irq_en,
  input  logic              clr_vld,
  input  logic [STS_W-1:0]  clr_mask,
  output logic [STS_W-1:0]  sts,
  output logic              bus_derr,
  output logic              irq
);

  logic             hit, wr_hit;
  logic [STS_W-1:0] set_v, clr_v, nxt;
  logic [STS_W-1:0] sts_q;
  logic             derr_q, irq_q;

  always_comb begin
    hit              = ld_vld && (|ld_uerr);
    wr_hit           = hit && (ld_kind == KIND_WR);
    set_v            = '0;
    set_v[STS_UDE]   = hit;
    set_v[STS_PWDE]  = wr_hit;
    set_v[STS_BWDE]  = wr_hit;
    clr_v            = clr_vld ? clr_mask : '0;
    nxt              = (sts_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= '0;
      derr_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sts_q  <= nxt;
      derr_q <= hit;
      irq_q  <= nxt[STS_UDE] && irq_en;
    end
  end

  assign sts      = sts_q;
  assign bus_derr = derr_q;
  assign irq      = irq_q;

endmodule

// File: rtl/uerr_mark_store.sv
module uerr_mark_store
  import uerr_pkg::*;
#(
  parameter int NSLICE    = 4,
  parameter int DEPTH     = 16,
  parameter int PKT_BEATS = 4,
  parameter int IW        = 4,
  parameter int GW        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_vld,
  input  xfer_kind_e        ld_kind,
  input  logic [IW-1:0]     ld_idx,
  input  logic [NSLICE-1:0] ld_uerr,
  input  logic              alloc_vld,
  input  logic [IW-1:0]     alloc_idx,
  input  logic [GW-1:0]     grp_sel,
  input  logic              wu_vld,
  input  logic [IW-1:0]     wu_idx,
  output logic [NSLICE-1:0] grp_err,
  output logic [NSLICE-1:0] bus_oe
);

  logic [NSLICE-1:0] rd_err [DEPTH];
  logic [NSLICE-1:0] lk_bad [DEPTH];
  logic [NSLICE-1:0] oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        rd_err[i] <= '0;
        lk_bad[i] <= '0;
      end
      oe_q <= '0;
    end else begin
      if (alloc_vld) begin
        rd_err[alloc_idx] <= '0;
        lk_bad[alloc_idx] <= '0;
      end
      if (ld_vld) begin
        rd_err[ld_idx] <= kind_is_read(ld_kind) ? ld_uerr : '0;
        lk_bad[ld_idx] <= (ld_kind == KIND_LOCK) ? ld_uerr : '0;
      end
      oe_q <= wu_vld ? ~lk_bad[wu_idx] : '0;
    end
  end

  always_comb begin
    grp_err = '0;
    for (int b = 0; b < PKT_BEATS; b++) begin
      grp_err = grp_err | rd_err[IW'(int'(grp_sel) * PKT_BEATS + b)];
    end
  end

  assign bus_oe = oe_q;

endmodule

// File: rtl/uerr_ret_seq.sv
module uerr_ret_seq #(
  parameter int NSLICE    = 4,
  parameter int PKT_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ret_start,
  input  logic [NSLICE-1:0] grp_err,
  output logic              ret_act,
  output logic [NSLICE-1:0] rer_sb,
  output logic              err_pkt
);

  localparam int CW = (PKT_BEATS > 1) ? $clog2(PKT_BEATS) : 1;

  logic [CW-1:0]     cnt_q;
  logic              busy_q, first_q, pkt_q;
  logic [NSLICE-1:0] rer_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      pkt_q   <= 1'b0;
      rer_q   <= '0;
    end else begin
      pkt_q   <= first_q && (|rer_q);
      first_q <= 1'b0;
      if (!busy_q) begin
        if (ret_start) begin
          busy_q  <= 1'b1;
          cnt_q   <= CW'(PKT_BEATS - 1);
          rer_q   <= grp_err;
          first_q <= 1'b1;
        end
      end else if (cnt_q == '0) begin
        busy_q <= 1'b0;
        rer_q  <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign ret_act = busy_q;
  assign rer_sb  = rer_q;
  assign err_pkt = pkt_q;

endmodule

// File: rtl/uerr_tagger.sv
module uerr_tagger
  import uerr_pkg::*;
#(
  parameter int NSLICE         = 4,
  parameter int DEPTH          = 16,
  parameter int PKT_BEATS      = 4,
  localparam int IW            = $clog2(DEPTH),
  localparam int GRPS          = DEPTH / PKT_BEATS,
  localparam int GW            = (GRPS > 1) ? $clog2(GRPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_vld,
  input  logic [1:0]        ld_kind,
  input  logic [IW-1:0]     ld_idx,
  input  logic [NSLICE-1:0] ld_uerr,
  input  logic              alloc_vld,
  input  logic [IW-1:0]     alloc_idx,
  input  logic              irq_en,
  input  logic              clr_vld,
  input  logic [2:0]        clr_mask,
  input  logic              ret_start,
  input  logic [GW-1:0]     ret_grp,
  input  logic              wu_vld,
  input  logic [IW-1:0]     wu_idx,
  output logic [2:0]        sts,
  output logic              bus_derr,
  output logic              irq,
  output logic              ret_act,
  output logic [NSLICE-1:0] rer_sb,
  output logic              err_pkt,
  output logic [NSLICE-1:0] bus_oe
);

  xfer_kind_e        kind;
  logic [NSLICE-1:0] grp_err;

  assign kind = xfer_kind_e'(ld_kind);

  uerr_status #(.NSLICE(NSLICE)) status_i (
    .clk      (clk),
    .rst      (rst),
    .ld_vld   (ld_vld),
    .ld_kind  (kind),
    .ld_uerr  (ld_uerr),
    .irq_en   (irq_en),
    .clr_vld  (clr_vld),
    .clr_mask (clr_mask),
    .sts      (sts),
    .bus_derr (bus_derr),
    .irq      (irq)
  );

  uerr_mark_store #(
    .NSLICE    (NSLICE),
    .DEPTH     (DEPTH),
    .PKT_BEATS (PKT_BEATS),
    .IW        (IW),
    .GW        (GW)
  ) store_i (
    .clk       (clk),
    .rst       (rst),
    .ld_vld    (ld_vld),
    .ld_kind   (kind),
    .ld_idx    (ld_idx),
    .ld_uerr   (ld_uerr),
    .alloc_vld (alloc_vld),
    .alloc_idx (alloc_idx),
    .grp_sel   (ret_grp),
    .wu_vld    (wu_vld),
    .wu_idx    (wu_idx),
    .grp_err   (grp_err),
    .bus_oe    (bus_oe)
  );

  uerr_ret_seq #(
    .NSLICE    (NSLICE),
    .PKT_BEATS (PKT_BEATS)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .ret_start (ret_start),
    .grp_err   (grp_err),
    .ret_act   (ret_act),
    .rer_sb    (rer_sb),
    .err_pkt   (err_pkt)
  );

endmodule

// File: rtl/uerr_tagger_chk.sv
module uerr_tagger_chk #(
  parameter int NSLICE = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_derr,
  input logic [2:0]        sts,
  input logic              irq,
  input logic              irq_en,
  input logic              ret_act,
  input logic [NSLICE-1:0] rer_sb,
  input logic              err_pkt,
  input logic [NSLICE-1:0] bus_oe,
  input logic              wu_vld
);

  // R1
  derr_sets_ude_chk: assert property (@(posedge clk) disable iff (rst)
    bus_derr |-> sts[0]);

  // R2
  wde_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[1]) |-> (bus_derr && sts[2]));

  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(irq_en) && sts[0]));

  // R5
  rer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_act && $past(ret_act)) |-> $stable(rer_sb));

  // R5
  rer_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ret_act |-> (rer_sb == '0));

  // R6
  err_pkt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_pkt |=> !err_pkt);

  // R6
  err_pkt_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err_pkt |-> ($past(ret_act) && ($past(rer_sb) != '0)));

  // R8
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wu_vld) |-> (bus_oe == '0));

endmodule

bind uerr_tagger uerr_tagger_chk #(.NSLICE(NSLICE)) chk_i (.*);

// File: tb/uerr_tagger_tb_top.sv
`timescale 1ns/1ps
module uerr_tagger_tb_top;

  localparam int NS = 4;
  localparam int DEPTH = 16;
  localparam int PB = 4;
  localparam int IW = 4;
  localparam int GW = 2;
  localparam int NROW = 8;

  // row: kind[13:12] idx[11:8] uerr[7:4] exp_sts[3:1] exp_derr[0]
  localparam logic [13:0] ROWS [NROW] = '{
    {2'd0, 4'd0, 4'b0001, 3'b111, 1'b1},
    {2'd1, 4'd1, 4'b0000, 3'b000, 1'b0},
    {2'd1, 4'd2, 4'b0100, 3'b001, 1'b1},
    {2'd2, 4'd3, 4'b1000, 3'b001, 1'b1},
    {2'd3, 4'd4, 4'b0011, 3'b001, 1'b1},
    {2'd0, 4'd5, 4'b0000, 3'b000, 1'b0},
    {2'd0, 4'd6, 4'b1111, 3'b111, 1'b1},
    {2'd3, 4'd7, 4'b0000, 3'b000, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_vld = 0, alloc_vld = 0, irq_en = 0, clr_vld = 0, ret_start = 0, wu_vld = 0;
  logic [1:0] ld_kind = 0;
  logic [IW-1:0] ld_idx = 0, alloc_idx = 0, wu_idx = 0;
  logic [NS-1:0] ld_uerr = 0;
  logic [2:0] clr_mask = 0;
  logic [GW-1:0] ret_grp = 0;
  logic [2:0] sts;
  logic bus_derr, irq, ret_act, err_pkt;
  logic [NS-1:0] rer_sb, bus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uerr_tagger #(.NSLICE(NS), .DEPTH(DEPTH), .PKT_BEATS(PB)) dut_i (.*);

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load(logic [1:0] k, logic [IW-1:0] i, logic [NS-1:0] u);
    ld_vld = 1; ld_kind = k; ld_idx = i; ld_uerr = u;
    cyc();
    ld_vld = 0;
  endtask

  task automatic wu(logic [IW-1:0] i);
    wu_vld = 1; wu_idx = i;
    cyc();
    wu_vld = 0;
  endtask

  task automatic clr(logic [2:0] m);
    clr_vld = 1; clr_mask = m;
    cyc();
    clr_vld = 0;
  endtask

  initial begin
    repeat (3) cyc();
    // R9 reset state
    chk("R9", "sts", sts, 0);
    chk("R9", "bus_derr", bus_derr, 0);
    chk("R9", "irq", irq, 0);
    chk("R9", "ret_act", ret_act, 0);
    chk("R9", "rer_sb", rer_sb, 0);
    chk("R9", "err_pkt", err_pkt, 0);
    chk("R9", "bus_oe", bus_oe, 0);
    rst = 0;
    cyc();

    // R1 R2 vector table
    for (int r = 0; r < NROW; r++) begin
      clr(3'b111);
      load(ROWS[r][13:12], ROWS[r][11:8], ROWS[r][7:4]);
      chk("R2", "sts", sts, ROWS[r][3:1]);
      chk("R1", "bus_derr", bus_derr, ROWS[r][0]);
      cyc();
      chk("R1", "bus_derr drop", bus_derr, 0);
    end

    // R5 R6 R7: group 0 (idx2 read 0100, idx3 iread 1000)
    ret_grp = 0; ret_start = 1;
    cyc();
    ret_start = 0;
    chk("R5", "rer beat1", rer_sb, 4'b1100);
    chk("R5", "act beat1", ret_act, 1);
    chk("R6", "err_pkt beat1", err_pkt, 0);
    cyc();
    chk("R6", "err_pkt beat2", err_pkt, 1);
    ret_grp = 1; ret_start = 1;
    cyc();
    ret_start = 0;
    chk("R6", "err_pkt beat3", err_pkt, 0);
    chk("R10", "rer beat3", rer_sb, 4'b1100);
    cyc();
    chk("R5", "rer beat4", rer_sb, 4'b1100);
    chk("R10", "act beat4", ret_act, 1);
    cyc();
    chk("R5", "act end", ret_act, 0);
    chk("R5", "rer end", rer_sb, 0);

    // R7: group 1 holds only write and lock flags
    ret_grp = 1; ret_start = 1;
    cyc();
    ret_start = 0;
    chk("R7", "rer grp1", rer_sb, 0);
    chk("R5", "act grp1", ret_act, 1);
    cyc();
    chk("R6", "no err_pkt", err_pkt, 0);
    repeat (4) cyc();

    // R8 lock marks
    wu(4'd4);
    chk("R8", "oe idx4", bus_oe, 4'b1100);
    cyc();
    chk("R8", "oe idle", bus_oe, 0);
    wu(4'd7);
    chk("R8", "oe idx7", bus_oe, 4'b1111);

    // R9 alloc clears marks
    alloc_vld = 1; alloc_idx = 4'd4;
    cyc();
    alloc_vld = 0;
    wu(4'd4);
    chk("R9", "oe after alloc", bus_oe, 4'b1111);
    alloc_vld = 1; alloc_idx = 4'd3;
    cyc();
    alloc_vld = 0;
    ret_grp = 0; ret_start = 1;
    cyc();
    ret_start = 0;
    chk("R9", "rer after alloc", rer_sb, 4'b0100);
    repeat (5) cyc();

    // R3 interrupt gating
    clr(3'b111);
    irq_en = 0;
    load(2'd1, 4'd9, 4'b0001);
    chk("R3", "irq disabled", irq, 0);
    irq_en = 1;
    cyc();
    chk("R3", "irq enabled", irq, 1);
    clr(3'b001);
    chk("R3", "irq after clear", irq, 0);
    chk("R4", "sts cleared", sts, 0);
    irq_en = 0;

    // R4 sticky and write-one-to-clear
    load(2'd0, 4'd10, 4'b0010);
    chk("R2", "sts write", sts, 3'b111);
    cyc();
    chk("R4", "sticky", sts, 3'b111);
    clr(3'b010);
    chk("R4", "partial clear", sts, 3'b101);
    clr_vld = 1; clr_mask = 3'b001;
    load(2'd1, 4'd11, 4'b0001);
    clr_vld = 0;
    chk("R4", "set wins", sts, 3'b101);

    // R8 then R9 reset clears marks
    load(2'd3, 4'd12, 4'b1010);
    wu(4'd12);
    chk("R8", "oe idx12", bus_oe, 4'b0101);
    rst = 1;
    cyc();
    rst = 0;
    chk("R9", "sts after reset", sts, 0);
    wu(4'd12);
    chk("R9", "oe after reset", bus_oe, 4'b1111);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule